// File: doc/BRIEF.md
# Digit-Serial Montgomery Multiplier

This block multiplies a coefficient that arrives as a stream of digits by a twiddle factor that is already in Montgomery form. It produces A·W·R⁻¹ mod q, with R = 2^WORD_W. The coefficient enters one DIG_W-bit digit per cycle, least significant digit first. The first digit is flagged by a start-of-word strobe, and the full-width twiddle is presented in that same cycle. The product leaves in the same digit format, so the next stage of a streaming transform can take it without rebuilding a full word.

Inside, the block is a systolic chain of processing elements, one per digit. Each element is a four-stage pipeline. It adds one digit of A times the twiddle to the running partial result, forms a DIG_W-bit Montgomery quotient from the low digit of that sum, adds the quotient times q, and drops the low DIG_W bits. The coefficient stream and the twiddle travel down a three-register tap line between elements. This way digit i reaches element i in the same cycle as the partial result from element i−1. No final subtraction of q is made. The result is left in the redundant range [0, 2q), which the next multiply in the pipeline accepts as it is.

Top module: `mdsm_mul`

## Requirements
- R1: For every word, the output value V, assembled from its digits, satisfies V·2^WORD_W ≡ A·W (mod q).
- R2: With A and W both below 2q and 4q < 2^WORD_W, every output value is below 2q.
- R3: Each result is emitted as exactly WORD_W/DIG_W digits on consecutive cycles with `out_valid` high. `out_sop` is high with the first digit only, and digit k carries bits [k·DIG_W +: DIG_W], least significant first.
- R4: The first output digit of a word appears exactly 4·(WORD_W/DIG_W) cycles after the cycle in which its first input digit is accepted.
- R5: Words may follow each other with no idle cycle or with any idle gap. Every word yields its own correct result, in arrival order.
- R6: The twiddle is taken only in the cycle where `in_sop` is high. Values on `in_twiddle` during the other digit cycles of a word do not change the result.
- R7: While reset is low, and afterwards until a word has passed through the block, `out_valid` stays low.
- R8: A coefficient of zero yields an output value of exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| in_valid | input | 1 | An input digit is present this cycle |
| in_sop | input | 1 | This input digit is digit 0 of a new word |
| in_digit | input | DIG_W | Coefficient digit, least significant first |
| in_twiddle | input | WORD_W | Montgomery-form twiddle; taken when `in_sop` is high |
| out_valid | output | 1 | An output digit is present |
| out_sop | output | 1 | This output digit is digit 0 of a result |
| out_digit | output | DIG_W | Result digit, least significant first |

## Verification
The range assertions on partial results (below 3q) and on final results (below 2q) rely on both A and the twiddle being less than 2q. They also rely on q being odd with its top two bits clear. The alignment and framing assertions rely on each word being sent as WORD_W/DIG_W valid digits in consecutive cycles, starting with `in_sop`, and on no new word beginning before the current one is complete. The stimulus meets the range contract by reducing every random 128-bit draw modulo 2q, and includes the directed extremes 0, 1 and 2q−1. It meets the framing contract by sending each word whole, either back to back with the previous word or after a random idle gap. On some words it drives random junk on the twiddle port in the non-start cycles.

// File: rtl/mdsm_pkg.sv
package mdsm_pkg;

   // Negated inverse of an odd value modulo 2^64, by Newton iteration.
   // Starting from x = q gives 3 correct bits; each step doubles them.
   function automatic logic [63:0] neg_inv64(input logic [63:0] q0);
      logic [63:0] x;
      x = q0;
      for (int k = 0; k < 6; k++) begin
         x = x * (64'd2 - q0 * x);
      end
      return -x;
   endfunction

endpackage

// File: rtl/mdsm_tap_pipe.sv
// Fixed-depth delay for the digit stream (valid, index, digit, twiddle).
module mdsm_tap_pipe #(
   parameter int WORD_W = 128,
   parameter int DIG_W  = 32,
   parameter int IW     = 2,
   parameter int DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [IW-1:0]     i_idx,
   input  logic [DIG_W-1:0]  i_digit,
   input  logic [WORD_W-1:0] i_tw,
   output logic              o_valid,
   output logic [IW-1:0]     o_idx,
   output logic [DIG_W-1:0]  o_digit,
   output logic [WORD_W-1:0] o_tw
);

   logic [DEPTH-1:0] v_q;
   logic [IW-1:0]     idx_q [DEPTH];
   logic [DIG_W-1:0]  dig_q [DEPTH];
   logic [WORD_W-1:0] tw_q  [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q[0] <= i_valid;
         for (int k = 1; k < DEPTH; k++) v_q[k] <= v_q[k-1];
      end
   end

   always_ff @(posedge clk) begin
      idx_q[0] <= i_idx;
      dig_q[0] <= i_digit;
      tw_q[0]  <= i_tw;
      for (int k = 1; k < DEPTH; k++) begin
         idx_q[k] <= idx_q[k-1];
         dig_q[k] <= dig_q[k-1];
         tw_q[k]  <= tw_q[k-1];
      end
   end

   assign o_valid = v_q[DEPTH-1];
   assign o_idx   = idx_q[DEPTH-1];
   assign o_digit = dig_q[DEPTH-1];
   assign o_tw    = tw_q[DEPTH-1];

endmodule

// File: rtl/mdsm_pe.sv
// One processing element: folds in digit IDX of A and one quotient digit,
// then divides by 2^DIG_W. Four register stages.
module mdsm_pe #(
   parameter int                WORD_W = 128,
   parameter int                DIG_W  = 32,
   parameter int                IW     = 2,
   parameter int                IDX    = 0,
   parameter logic [WORD_W-1:0] MOD    = '1,
   parameter logic [DIG_W-1:0]  QINV   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              t_valid,
   input  logic [WORD_W-1:0] t_val,
   input  logic              d_valid,
   input  logic [IW-1:0]     d_idx,
   input  logic [DIG_W-1:0]  d_digit,
   input  logic [WORD_W-1:0] d_tw,
   output logic              r_valid,
   output logic [WORD_W-1:0] r_val
);

   localparam int PW = WORD_W + DIG_W;
   localparam int TW = WORD_W + DIG_W + 1;
   localparam logic [WORD_W+1:0] BOUND3 = 3 * (WORD_W+2)'(MOD);

   logic              s1_v, s2_v, s3_v, s4_v;
   logic [WORD_W-1:0] s1_t;
   logic [PW-1:0]     s1_p;
   logic [TW-1:0]     s2_t, s3_t;
   logic [DIG_W-1:0]  s3_m;
   logic [WORD_W-1:0] s4_t;
   logic [TW-1:0]     red_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s2_v <= 1'b0;
         s3_v <= 1'b0;
         s4_v <= 1'b0;
      end else begin
         s1_v <= t_valid;
         s2_v <= s1_v;
         s3_v <= s2_v;
         s4_v <= s3_v;
      end
   end

   // stage 1: digit product, stage 2: accumulate,
   // stage 3: quotient digit, stage 4: reduce and shift
   always_ff @(posedge clk) begin
      s1_t <= t_val;
      s1_p <= PW'(d_digit) * PW'(d_tw);
      s2_t <= TW'(s1_t) + TW'(s1_p);
      s3_t <= s2_t;
      s3_m <= s2_t[DIG_W-1:0] * QINV;
      s4_t <= red_sum[DIG_W +: WORD_W];
   end

   always_comb red_sum = s3_t + TW'(s3_m) * TW'(MOD);

   assign r_valid = s4_v;
   assign r_val   = s4_t;

   // digit IDX of the word must meet the partial result from the previous element
   assert_digit_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      t_valid |-> (d_valid && d_idx == IW'(IDX)));

   // quotient digit must clear the low digit exactly, with no overflow past the shift
   assert_exact_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
      s3_v |-> (red_sum[DIG_W-1:0] == '0 && !red_sum[TW-1]));

   // partial results stay below 3q
   assert_partial_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> ((WORD_W+2)'(r_val) < BOUND3));

endmodule

// File: rtl/mdsm_ser.sv
// Turns each full-width result into a least-significant-first digit stream.
module mdsm_ser #(
   parameter int                WORD_W = 128,
   parameter int                DIG_W  = 32,
   parameter logic [WORD_W-1:0] MOD    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              r_valid,
   input  logic [WORD_W-1:0] r_val,
   output logic              out_valid,
   output logic              out_sop,
   output logic [DIG_W-1:0]  out_digit
);

   localparam int NDIG = WORD_W / DIG_W;
   localparam int CW   = $clog2(NDIG);
   localparam logic [WORD_W:0] BOUND2 = 2 * (WORD_W+1)'(MOD);

   logic [WORD_W-1:0] sh_q;
   logic [CW-1:0]     left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
         left_q    <= '0;
      end else if (r_valid) begin
         out_valid <= 1'b1;
         out_sop   <= 1'b1;
         left_q    <= CW'(NDIG - 1);
      end else begin
         out_sop <= 1'b0;
         if (left_q != '0) begin
            left_q <= left_q - 1'b1;
         end else begin
            out_valid <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (r_valid) sh_q <= r_val;
      else         sh_q <= sh_q >> DIG_W;
   end

   assign out_digit = sh_q[DIG_W-1:0];

   assert_result_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> ((WORD_W+1)'(r_val) < BOUND2));

   assert_frame_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> $past(out_valid));

   assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> (!out_valid || left_q == '0));

endmodule

// File: rtl/mdsm_mul.sv
module mdsm_mul #(
   parameter int                WORD_W = 128,
   parameter int                DIG_W  = 32,
   parameter logic [WORD_W-1:0] MOD    = 128'h3FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF61
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [DIG_W-1:0]  in_digit,
   input  logic [WORD_W-1:0] in_twiddle,
   output logic              out_valid,
   output logic              out_sop,
   output logic [DIG_W-1:0]  out_digit
);

   import mdsm_pkg::*;

   localparam int NDIG    = WORD_W / DIG_W;
   localparam int IW      = $clog2(NDIG);
   localparam int PE_LAT  = 4;
   localparam int TAP_DLY = PE_LAT - 1;
   localparam logic [DIG_W-1:0] QINV = DIG_W'(neg_inv64(64'(MOD)));

   if (WORD_W % DIG_W != 0) begin : g_bad_split
      $error("WORD_W must be a multiple of DIG_W");
   end
   if (NDIG < 2) begin : g_bad_count
      $error("at least two digits per word are required");
   end
   if (DIG_W > 64) begin : g_bad_digit
      $error("DIG_W above 64 is not supported by the quotient constant");
   end
   if (!MOD[0]) begin : g_even_mod
      $error("MOD must be odd");
   end
   if (MOD[WORD_W-1:WORD_W-2] != 2'b00) begin : g_mod_range
      $error("MOD must satisfy 4*MOD < 2^WORD_W");
   end

   // ---- input framing: digit index and twiddle hold ----
   logic [IW-1:0]     idx_q, cur_idx;
   logic [WORD_W-1:0] tw_hold_q, cur_tw;

   assign cur_idx = in_sop ? '0 : idx_q;
   assign cur_tw  = in_sop ? in_twiddle : tw_hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        idx_q <= '0;
      else if (in_valid) idx_q <= cur_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (in_valid && in_sop) tw_hold_q <= in_twiddle;
   end

   // ---- systolic chain ----
   logic              tap_v   [NDIG];
   logic [IW-1:0]     tap_idx [NDIG];
   logic [DIG_W-1:0]  tap_dig [NDIG];
   logic [WORD_W-1:0] tap_tw  [NDIG];
   logic              ch_v    [NDIG+1];
   logic [WORD_W-1:0] ch_val  [NDIG+1];

   assign tap_v[0]   = in_valid;
   assign tap_idx[0] = cur_idx;
   assign tap_dig[0] = in_digit;
   assign tap_tw[0]  = cur_tw;
   assign ch_v[0]    = in_valid && (cur_idx == '0);
   assign ch_val[0]  = '0;

   for (genvar i = 0; i < NDIG; i++) begin : g_pe
      mdsm_pe #(
         .WORD_W(WORD_W), .DIG_W(DIG_W), .IW(IW), .IDX(i), .MOD(MOD), .QINV(QINV)
      ) u_pe (
         .clk(clk), .rst_n(rst_n),
         .t_valid(ch_v[i]), .t_val(ch_val[i]),
         .d_valid(tap_v[i]), .d_idx(tap_idx[i]), .d_digit(tap_dig[i]), .d_tw(tap_tw[i]),
         .r_valid(ch_v[i+1]), .r_val(ch_val[i+1])
      );
      if (i < NDIG - 1) begin : g_tap
         mdsm_tap_pipe #(
            .WORD_W(WORD_W), .DIG_W(DIG_W), .IW(IW), .DEPTH(TAP_DLY)
         ) u_tap (
            .clk(clk), .rst_n(rst_n),
            .i_valid(tap_v[i]), .i_idx(tap_idx[i]), .i_digit(tap_dig[i]), .i_tw(tap_tw[i]),
            .o_valid(tap_v[i+1]), .o_idx(tap_idx[i+1]), .o_digit(tap_dig[i+1]), .o_tw(tap_tw[i+1])
         );
      end
   end

   mdsm_ser #(.WORD_W(WORD_W), .DIG_W(DIG_W), .MOD(MOD)) u_ser (
      .clk(clk), .rst_n(rst_n),
      .r_valid(ch_v[NDIG]), .r_val(ch_val[NDIG]),
      .out_valid(out_valid), .out_sop(out_sop), .out_digit(out_digit)
   );

   // a non-first digit must directly follow an unfinished word
   assert_word_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_sop) |-> ($past(in_valid) && $past(cur_idx) != IW'(NDIG - 1)));

   // a new word may start only after the previous one is complete
   assert_word_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |-> (!$past(in_valid) || $past(cur_idx) == IW'(NDIG - 1)));

endmodule

// File: tb/mdsm_mul_test.sv
module mdsm_mul_test;

   localparam int WW  = 128;
   localparam int DD  = 32;
   localparam int NN  = WW / DD;
   localparam int LAT = 4 * NN;
   localparam logic [WW-1:0]  Q     = 128'h3FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF61;
   localparam logic [255:0]   Q256  = 256'(Q);
   localparam logic [255:0]   TWO_Q = 2 * 256'(Q);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sop = 1'b0;
   logic [DD-1:0] in_digit = '0;
   logic [WW-1:0] in_twiddle = '0;
   logic          out_valid, out_sop;
   logic [DD-1:0] out_digit;

   int nchecks = 0;
   int nfails  = 0;
   int cyc     = 0;

   logic [WW-1:0] exp_a [$];
   logic [WW-1:0] exp_w [$];
   int            exp_t [$];
   bit            exp_s [$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   mdsm_mul #(.WORD_W(WW), .DIG_W(DD), .MOD(Q)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sop(in_sop), .in_digit(in_digit), .in_twiddle(in_twiddle),
      .out_valid(out_valid), .out_sop(out_sop), .out_digit(out_digit)
   );

   task automatic check(input bit ok, input string tag, input logic [255:0] act,
                        input logic [255:0] expv);
      nchecks++;
      if (!ok) begin
         nfails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [WW-1:0] rand_below_2q();
      logic [255:0] r;
      r = 256'({$urandom, $urandom, $urandom, $urandom});
      return WW'(r % TWO_Q);
   endfunction

   function automatic logic [255:0] mulmod(input logic [WW-1:0] a, input logic [WW-1:0] w);
      return (256'(a) * 256'(w)) % Q256;
   endfunction

   function automatic logic [255:0] unmont(input logic [WW-1:0] v);
      return (256'(v) << WW) % Q256;
   endfunction

   // send one word; junk_tw puts random data on the twiddle port for digits 1..NN-1
   task automatic send(input logic [WW-1:0] a, input logic [WW-1:0] w, input bit junk_tw);
      for (int k = 0; k < NN; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (k == 0);
         in_digit = a[k*DD +: DD];
         if (k == 0) begin
            in_twiddle = w;
            exp_a.push_back(a);
            exp_w.push_back(w);
            exp_t.push_back(cyc + 1);
            exp_s.push_back(junk_tw);
         end else begin
            in_twiddle = junk_tw ? {$urandom, $urandom, $urandom, $urandom} : w;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid   = 1'b0;
         in_sop     = 1'b0;
         in_digit   = DD'($urandom);
         in_twiddle = {$urandom, $urandom, $urandom, $urandom};
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
      $finish;
   endtask

   // ---- output monitor ----
   bit            collecting = 1'b0;
   int            col_k = 0;
   logic [WW-1:0] col_res = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (out_sop) begin
               if (collecting) check(1'b0, "R3 frame cut short", 256'(col_k), 256'(NN));
               collecting = 1'b1;
               col_k = 0;
               col_res = '0;
               if (exp_t.size() == 0) check(1'b0, "R7 output with no word sent", 256'(1), 256'(0));
               else check(cyc == exp_t[0] + LAT, "R4 latency", 256'(cyc - exp_t[0]), 256'(LAT));
            end else if (!collecting) begin
               check(1'b0, "R3 digit outside a frame", 256'(1), 256'(0));
            end
            if (collecting) begin
               col_res[col_k*DD +: DD] = out_digit;
               col_k++;
               if (col_k == NN) begin
                  collecting = 1'b0;
                  if (exp_a.size() != 0) begin
                     logic [WW-1:0] a, w;
                     bit j;
                     a = exp_a.pop_front();
                     w = exp_w.pop_front();
                     j = exp_s.pop_front();
                     void'(exp_t.pop_front());
                     check(unmont(col_res) == mulmod(a, w),
                           j ? "R6 twiddle junk leaked into result" : "R1 residue",
                           unmont(col_res), mulmod(a, w));
                     check(256'(col_res) < TWO_Q, "R2 range", 256'(col_res), TWO_Q);
                     if (a == '0) check(col_res == '0, "R8 zero operand", 256'(col_res), 256'(0));
                  end
               end
            end
         end else if (collecting) begin
            check(1'b0, "R3 gap inside frame", 256'(col_k), 256'(NN));
            collecting = 1'b0;
         end
      end
   end

   // ---- watchdog ----
   initial begin
      repeat (50000) @(posedge clk);
      nfails++;
      $display("FAIL R5 watchdog expired actual=%0d expected<50000", cyc);
      finish_run();
   end

   // ---- stimulus ----
   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R7 in reset", 256'(out_valid), 256'(0));
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R7 idle after reset", 256'(out_valid), 256'(0));
      end

      // directed corners
      send('0, rand_below_2q(), 1'b0);                 // R8
      idle(3);
      send(WW'(TWO_Q - 1), WW'(TWO_Q - 1), 1'b0);      // R2 extreme
      send(128'd1, 128'd1, 1'b0);                      // R5 back to back
      send(WW'(TWO_Q - 1), '0, 1'b0);
      send(WW'(Q), WW'(TWO_Q - 1), 1'b1);              // R6
      send('0, WW'(TWO_Q - 1), 1'b1);                  // R8 with junk twiddle
      idle(LAT + 2);

      // constrained random, mixing back-to-back and gapped words
      for (int n = 0; n < 60; n++) begin
         send(rand_below_2q(), rand_below_2q(), ($urandom % 3) == 0);
         if (($urandom % 2) == 0) idle(1 + ($urandom % 7));
      end
      idle(LAT + NN + 6);

      check(exp_a.size() == 0, "R5 every word returned", 256'(exp_a.size()), 256'(0));
      check(out_valid == 1'b0, "R3 stream idle at end", 256'(out_valid), 256'(0));
      finish_run();
   end

endmodule